// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two 16-bit stack pointers, one for user code and one for supervisor code. Each pointer has its own 8-bit bank register, and together they form a 24-bit stack address. A mode input chooses the active pair. A word push moves the active pointer down by two and then stores the word there. A word pop reads the word at the pointer and then moves the pointer up by two. Pointer arithmetic stays inside 16 bits, so the bank byte never changes because of a push or pop.

The block drives a simple memory request port. On each request the port carries the byte address, the write enable, two byte lanes and the write data. Read data comes back in the same cycle. When the address is even, a word access takes one memory cycle. When the address is odd, the access becomes two byte cycles, the low byte first. Software loads the pointers and banks through a register-write port. Their contents after reset are undefined, so they must be loaded before any stack traffic.

Top module: `dual_stack_unit`

## Requirements
- R1: When `sup_mode` is 1 at command acceptance, the system pointer is used and updated. When it is 0, the user pointer is used and updated.
- R2: Bits 23:16 of `mem_addr` come from the bank register of the stack that was selected at acceptance.
- R3: A push (`cmd_pop`=0) lowers the active pointer by 2 and stores the word at the new pointer. The data is little-endian: bits 7:0 go to the lower byte address and bits 15:8 go to the address plus 1.
- R4: A pop (`cmd_pop`=1) reads the word at the active pointer into `pop_data`, with the low byte taken from the lower address. It then raises that pointer by 2.
- R5: A push or pop leaves the inactive pointer and both bank registers unchanged.
- R6: When the access address is even, the command produces exactly one memory cycle with `mem_be`=2'b11 and `busy` high for one cycle.
- R7: When the access address is odd, the command produces two byte cycles with `mem_be`=2'b01. The first cycle is at the pointer address and carries the low byte in bits 7:0. The second is at the pointer plus 1 and carries the high byte in bits 7:0.
- R8: Pointer arithmetic and the high-byte address both wrap within 16 bits. The bank byte is never incremented or decremented.
- R9: `cmd_valid` has no effect while `busy` is high.
- R10: `sup_mode` is sampled only at acceptance. Changing it during a split access does not change the stack used.
- R11: Register-write encoding for `wr_sel`: 0 is the user pointer, 1 is the system pointer, 2 is the user bank, and 3 is the system bank. A bank write takes `wr_data[7:0]`. A write takes effect only when `busy` is low and `cmd_valid` is low in the same cycle; otherwise it is dropped.
- R12: For the cycle after reset, `busy`, `done` and `mem_req` are low.
- R13: `done` pulses for one cycle, in the cycle after the final memory cycle. `busy` is low in that cycle, and `pop_data` is valid from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | 1 selects the system stack, 0 selects the user stack |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_pop | input | 1 | 1 means pop, 0 means push |
| cmd_wdata | input | 16 | Word to push |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Word returned by the last pop |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R11) |
| wr_data | input | 16 | Register write value |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory write (push) |
| mem_addr | output | 24 | Byte address |
| mem_be | output | 2 | Lane enables: bit 0 is `mem_addr`, bit 1 is `mem_addr`+1 |
| mem_wdata | output | 16 | Write data, lane 0 in bits 7:0 |
| mem_rdata | input | 16 | Read data, valid in the request cycle |

## Verification
Two events can fall in the same cycle. The first is a register write arriving together with a command acceptance. The bench raises `wr_en` and `cmd_valid` on the same edge, then shows through the next push address that the command used the old pointer and that the write was dropped. The second is a mode change during a split access. The bench flips `sup_mode` between the two byte cycles and checks that both byte addresses carry the original bank. It then checks that only the original pointer moved.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    parameter int PTR_W  = 16;
    parameter int BANK_W = 8;
    parameter int DATA_W = 16;
    parameter int BYTE_W = 8;
    parameter int NSTK   = 2;
    localparam int ADDR_W = BANK_W + PTR_W;
    localparam int BE_W   = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              pop;
        logic              sys;
        logic [BANK_W-1:0] bank;
        logic [PTR_W-1:0]  addr;
        logic [PTR_W-1:0]  next;
        logic [DATA_W-1:0] wdata;
    } stack_op_t;

    function automatic logic [PTR_W-1:0] ptr_after(input logic [PTR_W-1:0] p, input logic pop);
        return pop ? p + PTR_W'(BE_W) : p - PTR_W'(BE_W);
    endfunction
endpackage

// File: rtl/dsp_regs.sv
module dsp_regs
    import dsp_pkg::*;
(
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         upd_en,
    input  logic                         upd_sys,
    input  logic [PTR_W-1:0]             upd_ptr,
    output logic [NSTK-1:0][PTR_W-1:0]   ptr_o,
    output logic [NSTK-1:0][BANK_W-1:0]  bank_o
);
    for (genvar g = 0; g < NSTK; g++) begin : g_stk
        logic [PTR_W-1:0]  ptr_q;
        logic [BANK_W-1:0] bank_q;

        // contents are undefined until software loads them
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == {1'b0, 1'(g)})
                ptr_q <= wr_data[PTR_W-1:0];
            else if (upd_en && upd_sys == 1'(g))
                ptr_q <= upd_ptr;
            if (wr_en && wr_sel == {1'b1, 1'(g)})
                bank_q <= wr_data[BANK_W-1:0];
        end

        assign ptr_o[g]  = ptr_q;
        assign bank_o[g] = bank_q;
    end

    // R11: a software write never lands in the same cycle as a stack update
    p_wr_upd_excl_r11: assert property (@(posedge clk) upd_en |-> !wr_en)
        else $error("software write collided with pointer update");
endmodule

// File: rtl/dsp_seq.sv
module dsp_seq
    import dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_pop,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              sup_mode,
    input  logic [PTR_W-1:0]  act_ptr,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] pop_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              upd_en,
    output logic              upd_sys,
    output logic [PTR_W-1:0]  upd_ptr
);
    seq_state_e state_q;
    stack_op_t  op_q;
    logic       accept;
    logic [PTR_W-1:0] acc_addr;

    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign acc_addr = cmd_pop ? act_ptr : ptr_after(act_ptr, 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            done     <= 1'b0;
            op_q     <= '0;
            pop_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q.pop   <= cmd_pop;
                    op_q.sys   <= sup_mode;
                    op_q.bank  <= act_bank;
                    op_q.addr  <= acc_addr;
                    op_q.next  <= ptr_after(act_ptr, cmd_pop);
                    op_q.wdata <= cmd_wdata;
                    state_q    <= acc_addr[0] ? ST_LO : ST_WORD;
                end
                ST_WORD: begin
                    if (op_q.pop) pop_data <= mem_rdata;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_LO: begin
                    if (op_q.pop) pop_data[BYTE_W-1:0] <= mem_rdata[BYTE_W-1:0];
                    state_q <= ST_HI;
                end
                ST_HI: begin
                    if (op_q.pop) pop_data[DATA_W-1:BYTE_W] <= mem_rdata[BYTE_W-1:0];
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = mem_req && !op_q.pop;
        mem_addr  = {op_q.bank, op_q.addr};
        mem_be    = BE_W'(1);
        mem_wdata = {{(DATA_W-BYTE_W){1'b0}}, op_q.wdata[BYTE_W-1:0]};
        case (state_q)
            ST_WORD: begin
                mem_be    = '1;
                mem_wdata = op_q.wdata;
            end
            ST_HI: begin
                mem_addr  = {op_q.bank, op_q.addr + PTR_W'(1)};
                mem_wdata = {{(DATA_W-BYTE_W){1'b0}}, op_q.wdata[DATA_W-1:BYTE_W]};
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign upd_en  = (state_q == ST_WORD) || (state_q == ST_HI);
    assign upd_sys = op_q.sys;
    assign upd_ptr = op_q.next;

    // R6: full-width cycles only at even addresses
    p_word_even_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_be == '1) |-> !mem_addr[0])
        else $error("word cycle at odd address");

    // R7 / R8: second byte follows the first at +1, same bank, 16-bit wrap
    p_hi_follows_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LO) |=> (mem_req && mem_be == BE_W'(1) &&
            mem_addr[ADDR_W-1:PTR_W] == $past(mem_addr[ADDR_W-1:PTR_W]) &&
            mem_addr[PTR_W-1:0] == $past(mem_addr[PTR_W-1:0]) + PTR_W'(1)))
        else $error("high byte cycle misplaced");

    // R10: selected stack stays fixed for the whole command
    p_sys_held_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req) && !$past(upd_en)) |-> $stable(mem_addr[ADDR_W-1:PTR_W]))
        else $error("bank changed inside a split access");
endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit
    import dsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sup_mode,
    input  logic        cmd_valid,
    input  logic        cmd_pop,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pop_data,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);
    logic [NSTK-1:0][PTR_W-1:0]  ptr_all;
    logic [NSTK-1:0][BANK_W-1:0] bank_all;
    logic             wr_go;
    logic             upd_en;
    logic             upd_sys;
    logic [PTR_W-1:0] upd_ptr;

    // command acceptance outranks a software write in the same cycle
    assign wr_go = wr_en && !busy && !cmd_valid;

    dsp_regs u_regs (
        .clk     (clk),
        .wr_en   (wr_go),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_sys (upd_sys),
        .upd_ptr (upd_ptr),
        .ptr_o   (ptr_all),
        .bank_o  (bank_all)
    );

    dsp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_pop   (cmd_pop),
        .cmd_wdata (cmd_wdata),
        .sup_mode  (sup_mode),
        .act_ptr   (ptr_all[sup_mode]),
        .act_bank  (bank_all[sup_mode]),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .pop_data  (pop_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .upd_en    (upd_en),
        .upd_sys   (upd_sys),
        .upd_ptr   (upd_ptr)
    );

    // R12: quiet after reset
    p_reset_quiet_r12: assert property (@(posedge clk) rst |=> (!mem_req && !done && !busy))
        else $error("activity right after reset");

    // R13: completion is a single-cycle pulse with the unit idle
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req) ##1 !done)
        else $error("done not a clean pulse");
endmodule

// File: tb/dual_stack_unit_tb.sv
`timescale 1ns/1ps
module dual_stack_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sup_mode = 1'b0, cmd_valid = 1'b0, cmd_pop = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] pop_data, mem_wdata, mem_rdata;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [23:0] mem_addr;
    logic [1:0]  mem_be;

    always #4 clk = ~clk;

    dual_stack_unit u_dut (
        .clk(clk), .rst(rst), .sup_mode(sup_mode), .cmd_valid(cmd_valid),
        .cmd_pop(cmd_pop), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .pop_data(pop_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte memory model, 1 KiB aliased on the low address bits
    logic [7:0] mem [0:1023];
    logic [9:0] ma;
    assign ma = mem_addr[9:0];
    assign mem_rdata = {mem[ma + 10'd1], mem[ma]};

    int nlog = 0;
    logic [23:0] log_addr [0:7];
    logic [1:0]  log_be   [0:7];
    logic [15:0] log_wd   [0:7];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we && mem_be[0]) mem[ma] <= mem_wdata[7:0];
            if (mem_we && mem_be[1]) mem[ma + 10'd1] <= mem_wdata[15:8];
            if (nlog < 8) begin
                log_addr[nlog] = mem_addr;
                log_be[nlog]   = mem_be;
                log_wd[nlog]   = mem_wdata;
            end
            nlog = nlog + 1;
        end
    end

    int total = 0, bad = 0;
    int busy_cyc;
    logic done_after;
    logic [15:0] got_pop;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_op(input logic pop, input logic sys, input logic [15:0] d);
        @(negedge clk);
        nlog = 0;
        cmd_valid = 1'b1; cmd_pop = pop; sup_mode = sys; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_cyc = 0;
        while (!done && busy_cyc < 10) begin
            if (busy) busy_cyc++;
            @(negedge clk);
        end
        got_pop = pop_data;
        chk(!busy, "R13 busy low with done", 32'(busy), 0);
        @(negedge clk);
        done_after = done;
    endtask

    typedef struct packed {
        logic        pop;
        logic        sys;
        logic [15:0] data;
        logic [23:0] addr;
        logic [15:0] rdata;
    } vec_t;

    // USP=F328 bank C6, SSP=1234 bank 56 beforehand
    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 16'hA624, 24'hC6F326, 16'h0000},
        '{1'b0, 1'b1, 16'hA624, 24'h561232, 16'h0000},
        '{1'b0, 1'b0, 16'h1357, 24'hC6F324, 16'h0000},
        '{1'b1, 1'b0, 16'h0000, 24'hC6F324, 16'h1357},
        '{1'b1, 1'b1, 16'h0000, 24'h561232, 16'hA624},
        '{1'b1, 1'b0, 16'h0000, 24'hC6F326, 16'hA624}
    };

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(!busy && !done && !mem_req, "R12 idle after reset",
            {29'd0, busy, done, mem_req}, 0);

        wreg(2'd0, 16'hF328); wreg(2'd1, 16'h1234);
        wreg(2'd2, 16'h00C6); wreg(2'd3, 16'hFF56);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            run_op(VEC[v].pop, VEC[v].sys, VEC[v].data);
            chk(nlog == 1, "R6 single cycle", 32'(nlog), 1);
            chk(log_addr[0] == VEC[v].addr, "R1/R2/R5 address", 32'(log_addr[0]), 32'(VEC[v].addr));
            chk(log_be[0] == 2'b11, "R6 word lanes", 32'(log_be[0]), 3);
            chk(busy_cyc == 1, "R6 busy one cycle", 32'(busy_cyc), 1);
            chk(!done_after, "R13 done pulse", 32'(done_after), 0);
            if (VEC[v].pop)
                chk(got_pop == VEC[v].rdata, "R4 pop data", 32'(got_pop), 32'(VEC[v].rdata));
            if (v == 0) begin
                chk(mem[10'h326] == 8'h24, "R3 low byte low address", 32'(mem[10'h326]), 32'h24);
                chk(mem[10'h327] == 8'hA6, "R3 high byte next address", 32'(mem[10'h327]), 32'hA6);
            end
        end

        // R7 odd pointer push, split low byte first
        wreg(2'd0, 16'h0101);
        run_op(1'b0, 1'b0, 16'hBEEF);
        chk(nlog == 2, "R7 two cycles", 32'(nlog), 2);
        chk(log_addr[0] == 24'hC600FF && log_be[0] == 2'b01 && log_wd[0][7:0] == 8'hEF,
            "R7 first byte", 32'(log_addr[0]), 32'hC600FF);
        chk(log_addr[1] == 24'hC60100 && log_be[1] == 2'b01 && log_wd[1][7:0] == 8'hBE,
            "R7 second byte", 32'(log_addr[1]), 32'hC60100);
        chk(busy_cyc == 2, "R7 busy two cycles", 32'(busy_cyc), 2);
        run_op(1'b1, 1'b0, 16'h0000);
        chk(got_pop == 16'hBEEF, "R7 R4 split pop data", 32'(got_pop), 32'hBEEF);

        // R8 wrap at 0x0001: bytes at FFFF then 0000, bank unchanged
        wreg(2'd0, 16'h0001);
        run_op(1'b0, 1'b0, 16'h55AA);
        chk(log_addr[0] == 24'hC6FFFF, "R8 wrap low byte", 32'(log_addr[0]), 32'hC6FFFF);
        chk(log_addr[1] == 24'hC60000, "R8 wrap high byte", 32'(log_addr[1]), 32'hC60000);
        run_op(1'b1, 1'b0, 16'h0000);
        chk(got_pop == 16'h55AA, "R8 wrapped pop", 32'(got_pop), 32'h55AA);
        chk(log_addr[1] == 24'hC60000, "R8 pop wrap", 32'(log_addr[1]), 32'hC60000);
        wreg(2'd1, 16'h0000);
        run_op(1'b0, 1'b1, 16'h1111);
        chk(log_addr[0] == 24'h56FFFE, "R8 even wrap", 32'(log_addr[0]), 32'h56FFFE);

        // R10 flag flips mid split; R9 extra command while busy
        wreg(2'd1, 16'h2001);
        wreg(2'd0, 16'h3000);
        @(negedge clk);
        nlog = 0;
        cmd_valid = 1'b1; cmd_pop = 1'b0; sup_mode = 1'b1; cmd_wdata = 16'h7788;
        @(negedge clk);
        sup_mode = 1'b0;            // cmd_valid still high: R9
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(nlog == 2, "R9 command ignored while busy", 32'(nlog), 2);
        chk(log_addr[0] == 24'h561FFF, "R10 first byte system bank", 32'(log_addr[0]), 32'h561FFF);
        chk(log_addr[1] == 24'h562000, "R10 second byte system bank", 32'(log_addr[1]), 32'h562000);
        run_op(1'b0, 1'b0, 16'h0000);
        chk(log_addr[0] == 24'hC62FFE, "R10 R5 user pointer untouched", 32'(log_addr[0]), 32'hC62FFE);

        // R11 write with command acceptance is dropped
        @(negedge clk);
        nlog = 0;
        cmd_valid = 1'b1; cmd_pop = 1'b0; sup_mode = 1'b0; cmd_wdata = 16'h4242;
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h4000;
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_sel = 2'd2; wr_data = 16'h0011;   // during busy: also dropped
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(log_addr[0] == 24'hC62FFC, "R11 command used old pointer", 32'(log_addr[0]), 32'hC62FFC);
        run_op(1'b0, 1'b0, 16'h0000);
        chk(log_addr[0] == 24'hC62FFA, "R11 writes dropped", 32'(log_addr[0]), 32'hC62FFA);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule